// File: doc/BRIEF.md
# Legacy Memory Region Attribute Decoder

This block sits between the CPU address path and the memory/bus routing logic. It looks at each physical access address and decides whether the read and the write side of that access are claimed by system DRAM or passed on to the legacy expansion bus. Only the area between 640 KB and 1 MB is programmable. The video window 0xA0000–0xBFFFF is governed by a system-management control byte and by the SMM-active input. The option-ROM area 0xC0000–0xEFFFF is split into twelve 16 KB segments. The top 64 KB holding the boot firmware forms one more region. Each segment and the top region has its own 2-bit read/write attribute.

Software programs the attributes through a byte-wide configuration port. The same port holds a DRAM size byte. Reset loads that byte from the installed memory size, given in megabytes. The routing outputs are combinational in the address, the SMM input and the stored registers. A new setting therefore takes effect on the first access that follows it.

Top module: `mem_attr_decoder`

## Requirements
- R1: Reset clears the seven attribute bytes at offsets 0x59–0x5F to 0x00 and sets the system-management control byte at offset 0x72 to 0x02. With every attribute at 0, each programmable segment starts on the bus.
- R2: A configuration write stores the data byte at offset 0x57, 0x59–0x5F or 0x72, and a read returns the stored byte. A read at any other offset returns 0x00, and a write there changes no register.
- R3: Addresses 0xF0000–0xFFFFF take their attribute from bits [5:4] of the byte at offset 0x59.
- R4: Addresses 0xC0000–0xEFFFF form segments k = (addr − 0xC0000) / 16384, for k = 0..11. Segment k takes its attribute from the byte at offset 0x5A + k/2: bits [1:0] when k is even, bits [5:4] when k is odd.
- R5: Attribute bit 0 routes reads to DRAM and attribute bit 1 routes writes to DRAM; a cleared bit routes that direction to the bus. Value 3 gives read/write DRAM, 1 gives read-only DRAM, 2 gives write-only DRAM, and 0 sends both directions to the bus.
- R6: Reads and writes to 0xA0000–0xBFFFF both go to DRAM when bit 6 of the 0x72 byte is set, or when bit 3 is set while smm_active is high. Otherwise both go to the bus.
- R7: A change on smm_active changes the routing in the same cycle. A configuration write changes the routing from the first clock edge that captures it, and not before that edge.
- R8: Addresses below 0xA0000 or at 0x100000 and above are routed to DRAM for both reads and writes, whatever the registers hold.
- R9: For every access, exactly one of rd_dram_sel and rd_bus_sel is high, and exactly one of wr_dram_sel and wr_bus_sel is high.
- R10: After reset, the byte at offset 0x57 holds dram_mb / 8, saturated at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dram_mb | input | 16 | Installed DRAM in MB, loaded into the size byte during reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset, for reads and writes |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| smm_active | input | 1 | Processor is in system-management mode |
| acc_addr | input | 32 | Physical address of the current access |
| rd_dram_sel | output | 1 | A read at acc_addr is claimed by DRAM |
| rd_bus_sel | output | 1 | A read at acc_addr is forwarded to the bus |
| wr_dram_sel | output | 1 | A write at acc_addr is claimed by DRAM |
| wr_bus_sel | output | 1 | A write at acc_addr is forwarded to the bus |

## Verification
The bench probes the first and last byte of every segment with two different attribute patterns. A design that swaps nibbles between even and odd segments, or that computes the segment index off by one, routes a neighbour's attribute and gets caught at those edges. Addresses one below 0xA0000, 0xEFFFF against 0xF0000, and 0x100000 catch a window bound that is off by one. The size byte is checked at 2047 and 2048 MB to expose a missing or misplaced saturation. The SMM input is toggled with no clock edge in between, and the routing is sampled once between a write strobe and its capturing edge. Together these expose a design that registers the decode or that lets the write data bypass the register.

// File: rtl/mem_attr_pkg.sv
package mem_attr_pkg;

  // configuration offsets the routing depends on
  localparam logic [7:0] ATTR_BASE_OFS = 8'h59;
  localparam logic [7:0] VIDCTL_OFS    = 8'h72;
  localparam logic [7:0] SIZE_OFS      = 8'h57;
  localparam logic [7:0] VIDCTL_RST    = 8'h02;

  // window bounds inside the first megabyte
  localparam logic [19:0] VID_BASE  = 20'hA0000;
  localparam logic [19:0] SEG_BASE  = 20'hC0000;
  localparam logic [19:0] TOP_BASE  = 20'hF0000;

  typedef enum logic [1:0] {
    WIN_PASS  = 2'd0,
    WIN_VIDEO = 2'd1,
    WIN_SEG   = 2'd2,
    WIN_TOP   = 2'd3
  } win_e;

  typedef struct packed {
    logic wr_dram;
    logic rd_dram;
  } route_t;

  // attribute bit0 = read to DRAM, bit1 = write to DRAM
  function automatic route_t attr_route(input logic [1:0] a);
    route_t r;
    r.rd_dram = a[0];
    r.wr_dram = a[1];
    return r;
  endfunction

  // megabytes to 8 MB units, clamped to one byte
  function automatic logic [7:0] dram_units(input logic [31:0] mb);
    logic [31:0] u;
    u = mb >> 3;
    return (u > 32'd255) ? 8'hFF : u[7:0];
  endfunction

endpackage

// File: rtl/mem_attr_cfg_regs.sv
module mem_attr_cfg_regs
  import mem_attr_pkg::*;
#(
  parameter int ATTR_BYTES = 7,
  parameter int MB_W       = 16,
  parameter int ATTR_W     = ATTR_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MB_W-1:0]   dram_mb,
  input  logic              wr_en,
  input  logic [7:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [ATTR_W-1:0] attr_flat,
  output logic [7:0]        vidctl_q
);

  logic [7:0] attr_q [ATTR_BYTES];
  logic [7:0] size_q;
  logic       vid_hit;
  logic       size_hit;

  assign vid_hit  = (addr == VIDCTL_OFS);
  assign size_hit = (addr == SIZE_OFS);

  for (genvar g = 0; g < ATTR_BYTES; g++) begin : g_attr
    localparam logic [7:0] OFS = 8'(ATTR_BASE_OFS + g);
    always_ff @(posedge clk) begin
      if (!rst_n)
        attr_q[g] <= 8'h00;
      else if (wr_en && addr == OFS)
        attr_q[g] <= wdata;
    end
    assign attr_flat[g*8 +: 8] = attr_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      vidctl_q <= VIDCTL_RST;
    else if (wr_en && vid_hit)
      vidctl_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      size_q <= dram_units(32'(dram_mb));
    else if (wr_en && size_hit)
      size_q <= wdata;
  end

  always_comb begin
    rdata = 8'h00;
    if (vid_hit)
      rdata = vidctl_q;
    else if (size_hit)
      rdata = size_q;
    for (int g = 0; g < ATTR_BYTES; g++) begin
      if (addr == 8'(ATTR_BASE_OFS + g))
        rdata = attr_q[g];
    end
  end

endmodule

// File: rtl/mem_attr_window.sv
module mem_attr_window
  import mem_attr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_SEG   = 12,
  parameter int SEG_SHIFT = 14,
  parameter int SEG_IDX_W = $clog2(NUM_SEG)
) (
  input  logic [ADDR_W-1:0]    addr,
  output win_e                 win,
  output logic [SEG_IDX_W-1:0] seg_idx
);

  logic        above_mb;
  logic [19:0] low20;
  logic [19:0] seg_off;

  if (ADDR_W > 20) begin : g_wide
    assign above_mb = |addr[ADDR_W-1:20];
  end else begin : g_narrow
    assign above_mb = 1'b0;
  end

  assign low20   = addr[19:0];
  assign seg_off = low20 - SEG_BASE;
  assign seg_idx = seg_off[SEG_SHIFT +: SEG_IDX_W];

  logic unused_off;
  assign unused_off = ^{seg_off[19:SEG_SHIFT+SEG_IDX_W], seg_off[SEG_SHIFT-1:0]};

  always_comb begin
    if (above_mb || low20 < VID_BASE)
      win = WIN_PASS;
    else if (low20 < SEG_BASE)
      win = WIN_VIDEO;
    else if (low20 < TOP_BASE)
      win = WIN_SEG;
    else
      win = WIN_TOP;
  end

endmodule

// File: rtl/mem_attr_lookup.sv
module mem_attr_lookup #(
  parameter int ATTR_BYTES = 7,
  parameter int NUM_SEG    = 12,
  parameter int ATTR_W     = ATTR_BYTES * 8,
  parameter int SEG_IDX_W  = $clog2(NUM_SEG)
) (
  input  logic [ATTR_W-1:0]    attr_flat,
  input  logic [SEG_IDX_W-1:0] seg_idx,
  output logic [1:0]           seg_attr,
  output logic [1:0]           top_attr
);

  logic [1:0] field [NUM_SEG];

  // segment s: byte 1 + s/2, low nibble for even s, high nibble for odd s
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_field
    localparam int BITPOS = (1 + s / 2) * 8 + (s % 2) * 4;
    assign field[s] = attr_flat[BITPOS +: 2];
  end

  assign top_attr = attr_flat[5:4];

  always_comb begin
    seg_attr = 2'b00;
    for (int s = 0; s < NUM_SEG; s++) begin
      if (seg_idx == SEG_IDX_W'(s))
        seg_attr = field[s];
    end
  end

  logic unused_attr;
  assign unused_attr = ^{attr_flat[7:6], attr_flat[3:0]};

endmodule

// File: rtl/mem_attr_decoder.sv
module mem_attr_decoder
  import mem_attr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MB_W       = 16,
  parameter int NUM_SEG    = 12,
  parameter int SEG_SHIFT  = 14,
  parameter int ATTR_BYTES = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MB_W-1:0]   dram_mb,
  input  logic              cfg_wr_en,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              smm_active,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              rd_dram_sel,
  output logic              rd_bus_sel,
  output logic              wr_dram_sel,
  output logic              wr_bus_sel
);

  localparam int ATTR_W    = ATTR_BYTES * 8;
  localparam int SEG_IDX_W = $clog2(NUM_SEG);

  logic [ATTR_W-1:0]    attr_flat;
  logic [7:0]           vidctl_q;
  win_e                 win;
  logic [SEG_IDX_W-1:0] seg_idx;
  logic [1:0]           seg_attr;
  logic [1:0]           top_attr;
  route_t               route;

  // named events for the checker
  logic region_pass;
  logic region_video;
  logic video_open;

  mem_attr_cfg_regs #(
    .ATTR_BYTES (ATTR_BYTES),
    .MB_W       (MB_W)
  ) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .dram_mb   (dram_mb),
    .wr_en     (cfg_wr_en),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .attr_flat (attr_flat),
    .vidctl_q  (vidctl_q)
  );

  mem_attr_window #(
    .ADDR_W    (ADDR_W),
    .NUM_SEG   (NUM_SEG),
    .SEG_SHIFT (SEG_SHIFT)
  ) win_i (
    .addr    (acc_addr),
    .win     (win),
    .seg_idx (seg_idx)
  );

  mem_attr_lookup #(
    .ATTR_BYTES (ATTR_BYTES),
    .NUM_SEG    (NUM_SEG)
  ) lut_i (
    .attr_flat (attr_flat),
    .seg_idx   (seg_idx),
    .seg_attr  (seg_attr),
    .top_attr  (top_attr)
  );

  assign region_pass  = (win == WIN_PASS);
  assign region_video = (win == WIN_VIDEO);
  assign video_open   = vidctl_q[6] | (vidctl_q[3] & smm_active);

  always_comb begin
    unique case (win)
      WIN_VIDEO: route = '{wr_dram: video_open, rd_dram: video_open};
      WIN_SEG:   route = attr_route(seg_attr);
      WIN_TOP:   route = attr_route(top_attr);
      default:   route = '{wr_dram: 1'b1, rd_dram: 1'b1};
    endcase
  end

  assign rd_dram_sel = route.rd_dram;
  assign rd_bus_sel  = ~route.rd_dram;
  assign wr_dram_sel = route.wr_dram;
  assign wr_bus_sel  = ~route.wr_dram;

  logic unused_ctl;
  assign unused_ctl = ^{vidctl_q[7], vidctl_q[5:4], vidctl_q[2:0]};

endmodule

// File: rtl/mem_attr_decoder_chk.sv
module mem_attr_decoder_chk
  import mem_attr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr_en,
  input logic [7:0] cfg_addr,
  input logic [7:0] cfg_wdata,
  input logic       smm_active,
  input logic [7:0] vidctl_q,
  input logic       region_pass,
  input logic       region_video,
  input logic       rd_dram_sel,
  input logic       rd_bus_sel,
  input logic       wr_dram_sel,
  input logic       wr_bus_sel
);

  // R9
  rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dram_sel ^ rd_bus_sel);

  // R9
  wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dram_sel ^ wr_bus_sel);

  // R8
  pass_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    region_pass |-> (rd_dram_sel && wr_dram_sel));

  // R6
  video_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region_video && (vidctl_q[6] || (vidctl_q[3] && smm_active)))
      |-> (rd_dram_sel && wr_dram_sel));

  // R6
  video_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region_video && !vidctl_q[6] && !(vidctl_q[3] && smm_active))
      |-> (rd_bus_sel && wr_bus_sel));

  // R2
  vidctl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_addr == VIDCTL_OFS) |=> (vidctl_q == $past(cfg_wdata)));

  // R1
  vidctl_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (vidctl_q == VIDCTL_RST));

endmodule

bind mem_attr_decoder mem_attr_decoder_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_wr_en    (cfg_wr_en),
  .cfg_addr     (cfg_addr),
  .cfg_wdata    (cfg_wdata),
  .smm_active   (smm_active),
  .vidctl_q     (vidctl_q),
  .region_pass  (region_pass),
  .region_video (region_video),
  .rd_dram_sel  (rd_dram_sel),
  .rd_bus_sel   (rd_bus_sel),
  .wr_dram_sel  (wr_dram_sel),
  .wr_bus_sel   (wr_bus_sel)
);

// File: tb/mem_attr_decoder_tb.sv
module mem_attr_decoder_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] dram_mb = 16'd0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        smm_active = 1'b0;
  logic [31:0] acc_addr = 32'h0;
  logic        rd_dram_sel, rd_bus_sel, wr_dram_sel, wr_bus_sel;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // bench-side copies of the programmed state
  logic [7:0] sh_attr [7];
  logic [7:0] sh_vid;
  logic [7:0] sh_size;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_attr_decoder dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .dram_mb     (dram_mb),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .smm_active  (smm_active),
    .acc_addr    (acc_addr),
    .rd_dram_sel (rd_dram_sel),
    .rd_bus_sel  (rd_bus_sel),
    .wr_dram_sel (wr_dram_sel),
    .wr_bus_sel  (wr_bus_sel)
  );

  function automatic logic [7:0] size_model(input int mb);
    if (mb >= 2048) return 8'd255;
    return 8'(mb / 8);
  endfunction

  // returns {write_to_dram, read_to_dram}
  function automatic logic [1:0] route_model(input logic [31:0] a);
    logic [7:0] b;
    int k;
    logic on;
    if (a < 32'h000A_0000 || a >= 32'h0010_0000) return 2'b11;
    if (a < 32'h000C_0000) begin
      on = sh_vid[6] | (sh_vid[3] & smm_active);
      return {on, on};
    end
    if (a >= 32'h000F_0000) return {sh_attr[0][5], sh_attr[0][4]};
    k = int'((a - 32'h000C_0000) / 32'd16384);
    b = sh_attr[1 + k / 2];
    if (k % 2 == 1) return {b[5], b[4]};
    return {b[1], b[0]};
  endfunction

  task automatic check_route(input logic [31:0] a, input string req);
    logic [1:0] e;
    logic [3:0] got, exp;
    acc_addr = a;
    #1;
    e   = route_model(a);
    exp = {e[0], ~e[0], e[1], ~e[1]};
    got = {rd_dram_sel, rd_bus_sel, wr_dram_sel, wr_bus_sel};
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h actual rd_d/rd_b/wr_d/wr_b=%b expected=%b", req, a, got, exp);
    end
  endtask

  task automatic check_read(input logic [7:0] ofs, input logic [7:0] exp, input string req);
    cfg_addr = ofs;
    #1;
    n_checks++;
    if (cfg_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s read ofs=%h actual=%h expected=%h", req, ofs, cfg_rdata, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] ofs, input logic [7:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_addr  = ofs;
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    if (ofs >= 8'h59 && ofs <= 8'h5F) sh_attr[ofs - 8'h59] = d;
    else if (ofs == 8'h72) sh_vid = d;
    else if (ofs == 8'h57) sh_size = d;
  endtask

  task automatic do_reset(input int mb);
    @(negedge clk);
    rst_n   = 1'b0;
    dram_mb = 16'(mb);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 7; i++) sh_attr[i] = 8'h00;
    sh_vid  = 8'h02;
    sh_size = size_model(mb);
  endtask

  // R1 R10: reset contents and size saturation
  task automatic t_reset_state();
    int mbs [4] = '{7, 2047, 2048, 768};
    foreach (mbs[j]) begin
      do_reset(mbs[j]);
      check_read(8'h57, size_model(mbs[j]), "R10");
    end
    for (int i = 0; i < 7; i++) check_read(8'(8'h59 + i), 8'h00, "R1");
    check_read(8'h72, 8'h02, "R1");
    for (int k = 0; k < 12; k++) check_route(32'h000C_0000 + 32'(k) * 32'h4000, "R1");
    check_route(32'h000F_8000, "R1");
  endtask

  // R2: mapped offsets store, others read zero and ignore writes
  task automatic t_cfg_port();
    cfg_write(8'h57, 8'hA5);
    check_read(8'h57, 8'hA5, "R2");
    for (int i = 0; i < 7; i++) cfg_write(8'(8'h59 + i), 8'(8'h11 * (i + 1)));
    for (int i = 0; i < 7; i++) check_read(8'(8'h59 + i), 8'(8'h11 * (i + 1)), "R2");
    cfg_write(8'h58, 8'hFF);
    cfg_write(8'h60, 8'hFF);
    cfg_write(8'h71, 8'hFF);
    check_read(8'h58, 8'h00, "R2");
    check_read(8'h60, 8'h00, "R2");
    check_read(8'h71, 8'h00, "R2");
    check_read(8'h59, 8'h11, "R2");
    check_read(8'h5F, 8'h77, "R2");
    check_read(8'h72, 8'h02, "R2");
    check_read(8'h57, 8'hA5, "R2");
  endtask

  // R3 R5: top region under each attribute value
  task automatic t_top_region();
    cfg_write(8'h5F, 8'h00);
    for (int v = 0; v < 4; v++) begin
      cfg_write(8'h59, 8'(v << 4) | 8'h0F);
      check_route(32'h000F_0000, "R3");
      check_route(32'h000F_FFFF, "R5");
      check_route(32'h000E_FFFF, "R3");
    end
  endtask

  // R4 R5: every segment edge under two patterns
  task automatic t_segments();
    logic [7:0] pat_a [6] = '{8'h31, 8'h02, 8'h13, 8'h20, 8'h33, 8'h10};
    logic [7:0] pat_b [6] = '{8'hC2, 8'hE3, 8'hD1, 8'hF0, 8'h4C, 8'h8B};
    for (int p = 0; p < 2; p++) begin
      for (int b = 0; b < 6; b++) cfg_write(8'(8'h5A + b), (p == 0) ? pat_a[b] : pat_b[b]);
      for (int k = 0; k < 12; k++) begin
        check_route(32'h000C_0000 + 32'(k) * 32'h4000, "R4");
        check_route(32'h000C_3FFF + 32'(k) * 32'h4000, "R5");
      end
    end
  endtask

  // R6: video window under control and SMM combinations
  task automatic t_video();
    logic [7:0] ctl [4] = '{8'h02, 8'h08, 8'h40, 8'hB7};
    foreach (ctl[j]) begin
      cfg_write(8'h72, ctl[j]);
      for (int s = 0; s < 2; s++) begin
        smm_active = s[0];
        check_route(32'h000A_0000, "R6");
        check_route(32'h000B_FFFF, "R6");
      end
    end
    smm_active = 1'b0;
  endtask

  // R7: SMM takes effect without a clock, a write only at its edge
  task automatic t_timing();
    cfg_write(8'h72, 8'h08);
    @(negedge clk);
    smm_active = 1'b0;
    check_route(32'h000A_8000, "R7");
    smm_active = 1'b1;
    check_route(32'h000A_8000, "R7");
    smm_active = 1'b0;
    check_route(32'h000A_8000, "R7");
    cfg_write(8'h59, 8'h00);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_addr  = 8'h59;
    cfg_wdata = 8'h30;
    check_route(32'h000F_1000, "R7");
    @(negedge clk);
    cfg_wr_en  = 1'b0;
    sh_attr[0] = 8'h30;
    check_route(32'h000F_1000, "R7");
  endtask

  // R8: outside the window always DRAM
  task automatic t_outside();
    for (int i = 0; i < 7; i++) cfg_write(8'(8'h59 + i), 8'h00);
    cfg_write(8'h72, 8'h00);
    check_route(32'h0000_0000, "R8");
    check_route(32'h0009_FFFF, "R8");
    check_route(32'h000A_0000, "R8");
    check_route(32'h0010_0000, "R8");
    check_route(32'h010C_0000, "R8");
    check_route(32'hFFFF_FFFF, "R8");
  endtask

  initial begin
    for (int i = 0; i < 7; i++) sh_attr[i] = 8'h00;
    sh_vid  = 8'h02;
    sh_size = 8'h00;
    t_reset_state();
    t_cfg_port();
    t_top_region();
    t_segments();
    t_video();
    t_timing();
    t_outside();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL R7 watchdog actual=running expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule